// File: doc/BRIEF.md
# Fine-Grained Label Ingress Encapsulator

This block sits on the ingress side of a routing bridge port. For every native frame it receives a short descriptor: the ingress port number, whether the frame carried a customer VLAN tag, the VLAN ID, and the frame's priority and drop-eligible bit. From these it produces the inner label section of the encapsulation header. Software programs the block through three write-only register strobes: a per-port associative mapping table, per-port mode settings, and a bitmap of VLAN IDs that are reserved for plain VLAN labelling.

A port in fine-grained mode maps (port, VLAN) to a 24-bit label written (X.Y), with X the upper 12 bits and Y the lower 12 bits. It then emits eight bytes: a C-tag EtherType, a first label part with the transport priority and X, an extension EtherType, and a second label part with the original priority and Y. Some frames must not be carried. These are frames whose mapping is missing, whose X is 0x000 or 0xFFF, or whose X is one of the reserved VLAN IDs. The block marks such frames for dropping. A port left in plain mode gets an ordinary four-byte VLAN tag. The result is registered and offered on a valid/ready output.

Top module: `fgl_ingress_encap`

## Requirements
- R1: A fine-grained header is 64 bits, sent most significant byte first: bits 63:48 = 0x8100, bits 47:32 = first part, bits 31:16 = 0x893B, bits 15:0 = second part.
- R2: The first part carries X (label bits 23:12) in its bits 11:0. The second part carries Y (label bits 11:0) in its bits 11:0.
- R3: Bits 15:13 of the second part hold the frame's original priority, and bit 12 holds its original drop-eligible bit.
- R4: Bits 15:12 of the first part hold the port's configured priority and drop-eligible bit when the port's remap bit is set. Otherwise they hold the original values.
- R5: The label comes from the first valid table entry, lowest index first, among the entries of the ingress port whose VLAN ID equals the frame's VLAN ID. Clearing an entry's valid bit removes it from the search.
- R6: An untagged frame is looked up and tagged as VLAN 1, whatever its VLAN ID field holds.
- R7: In fine-grained mode a frame with no matching entry has out_drop = 1 and out_hdr = 0.
- R8: A label whose X is 0x000 or 0xFFF gives out_drop = 1 and out_hdr = 0.
- R9: A label whose X is below VLS_COUNT and whose bit is set in the reserved bitmap gives out_drop = 1 and out_hdr = 0. An X at or above VLS_COUNT is never reserved.
- R10: A port whose fine bit is clear gives out_fine = 0 and out_drop = 0. Its bits 63:32 are {0x8100, priority, drop-eligible, VLAN ID} and bits 31:0 are zero.
- R11: The result appears one cycle after a descriptor is accepted. While out_valid = 1 and out_ready = 0, the output holds steady and in_ready = 0. Otherwise in_ready = 1.
- R12: After reset out_valid = 0, every table entry is invalid, every port is in plain mode with remap off, and the reserved bitmap is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_tbl_we | input | 1 | Write strobe for one mapping table entry |
| cfg_tbl_port | input | PORT_W | Port whose table is written |
| cfg_tbl_idx | input | IDX_W | Entry index within that port |
| cfg_tbl_valid | input | 1 | Valid bit of the written entry |
| cfg_tbl_vid | input | 12 | VLAN ID key of the entry |
| cfg_tbl_label | input | 24 | Fine-grained label of the entry |
| cfg_port_we | input | 1 | Write strobe for one port's settings |
| cfg_port_sel | input | PORT_W | Port whose settings are written |
| cfg_port_fine | input | 1 | 1 = fine-grained mode, 0 = plain VLAN tag |
| cfg_port_remap | input | 1 | 1 = use the configured transport priority |
| cfg_port_pcp | input | 3 | Configured transport priority |
| cfg_port_dei | input | 1 | Configured transport drop-eligible bit |
| cfg_vls_we | input | 1 | Write strobe for the reserved VLAN bitmap |
| cfg_vls_map | input | VLS_COUNT | Bit n set = VLAN ID n reserved for plain labelling |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Descriptor accepted when high with in_valid |
| in_port | input | PORT_W | Ingress port number |
| in_tagged | input | 1 | Frame carried a VLAN tag |
| in_vid | input | 12 | VLAN ID from the tag |
| in_pcp | input | 3 | Original priority |
| in_dei | input | 1 | Original drop-eligible bit |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_hdr | output | 64 | Label section, first byte in bits 63:56 |
| out_fine | output | 1 | 1 = eight-byte section, 0 = four-byte tag in bits 63:32 |
| out_drop | output | 1 | Frame must be discarded |

## Verification
The bench aims at the boundary values of X. It tries 0x000 and 0xFFF, a reserved ID just inside the bitmap, and the first ID past it with every bitmap bit set. A design that decodes the bitmap too widely or misses a reserved value would let a forbidden label through, or drop a legal one. Duplicate keys in one port's table are exercised to show that the lowest index wins and that invalidating it exposes the next one. Untagged frames with a random VLAN ID field are sent to catch a design that looks up the raw field instead of VLAN 1. The stall test offers a second descriptor while the output is blocked. A design that accepts it too early, or changes the held result, would lose or corrupt a header.

// File: rtl/fgl_pkg.sv
package fgl_pkg;

  localparam logic [15:0] ETYPE_CTAG  = 16'h8100;
  localparam logic [15:0] ETYPE_XTAG  = 16'h893B;
  localparam logic [11:0] UNTAGGED_VID = 12'd1;

  typedef struct packed {
    logic        valid;
    logic [11:0] vid;
    logic [23:0] label;
  } map_entry_t;

  typedef struct packed {
    logic       fine;
    logic       remap;
    logic [2:0] pcp;
    logic       dei;
  } port_cfg_t;

  // Builds a 16-bit label part from priority, drop-eligible bit and 12-bit ID.
  function automatic logic [15:0] pack_part(input logic [2:0] pcp, input logic dei,
                                            input logic [11:0] id);
    return {pcp, dei, id};
  endfunction

  // Upper-half values that may never appear on the wire.
  function automatic logic upper_reserved(input logic [11:0] x);
    return (x == 12'h000) || (x == 12'hFFF);
  endfunction

endpackage

// File: rtl/fgl_map_table.sv
module fgl_map_table
  import fgl_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DEPTH     = 8,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [IDX_W-1:0]  wr_idx,
  input  map_entry_t        wr_entry,
  input  logic [PORT_W-1:0] lk_port,
  input  logic [11:0]       lk_vid,
  output logic              lk_hit,
  output logic [23:0]       lk_label
);

  map_entry_t tbl [NUM_PORTS][DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PORTS; p++)
        for (int e = 0; e < DEPTH; e++)
          tbl[p][e] <= '0;
    end else if (wr_en) begin
      tbl[wr_port][wr_idx] <= wr_entry;
    end
  end

  logic [DEPTH-1:0] match;
  logic [23:0]      cand [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = tbl[lk_port][g].valid && (tbl[lk_port][g].vid == lk_vid);
    assign cand[g]  = tbl[lk_port][g].label;
  end

  // Lowest index wins: scan downward so the last assignment is the lowest hit.
  always_comb begin
    lk_hit   = 1'b0;
    lk_label = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) begin
        lk_hit   = 1'b1;
        lk_label = cand[i];
      end
    end
  end

endmodule

// File: rtl/fgl_port_cfg.sv
module fgl_port_cfg
  import fgl_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int VLS_COUNT = 64,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [PORT_W-1:0]    wr_port,
  input  port_cfg_t            wr_cfg,
  input  logic                 vls_we,
  input  logic [VLS_COUNT-1:0] vls_in,
  input  logic [PORT_W-1:0]    rd_port,
  output port_cfg_t            rd_cfg,
  output logic [VLS_COUNT-1:0] vls_map
);

  port_cfg_t cfg [NUM_PORTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PORTS; p++) cfg[p] <= '0;
      vls_map <= '0;
    end else begin
      if (wr_en)  cfg[wr_port] <= wr_cfg;
      if (vls_we) vls_map      <= vls_in;
    end
  end

  assign rd_cfg = cfg[rd_port];

endmodule

// File: rtl/fgl_hdr_build.sv
module fgl_hdr_build
  import fgl_pkg::*;
#(
  parameter int VLS_COUNT = 64
) (
  input  port_cfg_t            cfg,
  input  logic                 hit,
  input  logic [23:0]          label,
  input  logic [VLS_COUNT-1:0] vls_map,
  input  logic [11:0]          vid,
  input  logic [2:0]           pcp,
  input  logic                 dei,
  output logic [63:0]          hdr,
  output logic                 fine,
  output logic                 drop,
  output logic                 drop_miss,
  output logic                 drop_rsv,
  output logic                 drop_vls
);

  logic [11:0] up_x;
  logic [11:0] lo_y;
  logic [2:0]  tx_pcp;
  logic        tx_dei;
  logic        vls_hit;

  assign up_x   = label[23:12];
  assign lo_y   = label[11:0];
  assign tx_pcp = cfg.remap ? cfg.pcp : pcp;
  assign tx_dei = cfg.remap ? cfg.dei : dei;

  always_comb begin
    vls_hit = 1'b0;
    for (int k = 0; k < VLS_COUNT; k++)
      if (vls_map[k] && (up_x == 12'(k))) vls_hit = 1'b1;
  end

  assign fine      = cfg.fine;
  assign drop_miss = cfg.fine && !hit;
  assign drop_rsv  = cfg.fine && hit && upper_reserved(up_x);
  assign drop_vls  = cfg.fine && hit && vls_hit;
  assign drop      = drop_miss || drop_rsv || drop_vls;

  always_comb begin
    if (!cfg.fine)
      hdr = {ETYPE_CTAG, pack_part(pcp, dei, vid), 32'h0};
    else if (drop)
      hdr = '0;
    else
      hdr = {ETYPE_CTAG, pack_part(tx_pcp, tx_dei, up_x),
             ETYPE_XTAG, pack_part(pcp, dei, lo_y)};
  end

endmodule

// File: rtl/fgl_ingress_encap.sv
module fgl_ingress_encap
  import fgl_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DEPTH     = 8,
  parameter int VLS_COUNT = 64,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_tbl_we,
  input  logic [PORT_W-1:0]    cfg_tbl_port,
  input  logic [IDX_W-1:0]     cfg_tbl_idx,
  input  logic                 cfg_tbl_valid,
  input  logic [11:0]          cfg_tbl_vid,
  input  logic [23:0]          cfg_tbl_label,
  input  logic                 cfg_port_we,
  input  logic [PORT_W-1:0]    cfg_port_sel,
  input  logic                 cfg_port_fine,
  input  logic                 cfg_port_remap,
  input  logic [2:0]           cfg_port_pcp,
  input  logic                 cfg_port_dei,
  input  logic                 cfg_vls_we,
  input  logic [VLS_COUNT-1:0] cfg_vls_map,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [PORT_W-1:0]    in_port,
  input  logic                 in_tagged,
  input  logic [11:0]          in_vid,
  input  logic [2:0]           in_pcp,
  input  logic                 in_dei,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [63:0]          out_hdr,
  output logic                 out_fine,
  output logic                 out_drop
);

  // Effective VLAN: untagged frames belong to VLAN 1.
  logic [11:0] eff_vid;
  assign eff_vid = in_tagged ? in_vid : UNTAGGED_VID;

  map_entry_t wr_entry;
  assign wr_entry = '{valid: cfg_tbl_valid, vid: cfg_tbl_vid, label: cfg_tbl_label};

  port_cfg_t wr_cfg;
  assign wr_cfg = '{fine: cfg_port_fine, remap: cfg_port_remap,
                    pcp: cfg_port_pcp, dei: cfg_port_dei};

  logic        lk_hit;
  logic [23:0] lk_label;

  fgl_map_table #(.NUM_PORTS(NUM_PORTS), .DEPTH(DEPTH)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_tbl_we),
    .wr_port  (cfg_tbl_port),
    .wr_idx   (cfg_tbl_idx),
    .wr_entry (wr_entry),
    .lk_port  (in_port),
    .lk_vid   (eff_vid),
    .lk_hit   (lk_hit),
    .lk_label (lk_label)
  );

  port_cfg_t           cur_cfg;
  logic [VLS_COUNT-1:0] vls_map;

  fgl_port_cfg #(.NUM_PORTS(NUM_PORTS), .VLS_COUNT(VLS_COUNT)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_port_we),
    .wr_port (cfg_port_sel),
    .wr_cfg  (wr_cfg),
    .vls_we  (cfg_vls_we),
    .vls_in  (cfg_vls_map),
    .rd_port (in_port),
    .rd_cfg  (cur_cfg),
    .vls_map (vls_map)
  );

  logic [63:0] nxt_hdr;
  logic        nxt_fine;
  logic        nxt_drop;
  logic        drop_miss;
  logic        drop_rsv;
  logic        drop_vls;

  fgl_hdr_build #(.VLS_COUNT(VLS_COUNT)) u_build (
    .cfg       (cur_cfg),
    .hit       (lk_hit),
    .label     (lk_label),
    .vls_map   (vls_map),
    .vid       (eff_vid),
    .pcp       (in_pcp),
    .dei       (in_dei),
    .hdr       (nxt_hdr),
    .fine      (nxt_fine),
    .drop      (nxt_drop),
    .drop_miss (drop_miss),
    .drop_rsv  (drop_rsv),
    .drop_vls  (drop_vls)
  );

  logic accept;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hdr   <= '0;
      out_fine  <= 1'b0;
      out_drop  <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_hdr   <= nxt_hdr;
      out_fine  <= nxt_fine;
      out_drop  <= nxt_drop;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // Output stage handshake.
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_hdr) && $stable(out_drop) && $stable(out_fine));
  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // Header content.
  p_etype_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fine && !out_drop |->
      out_hdr[63:48] == ETYPE_CTAG && out_hdr[31:16] == ETYPE_XTAG);
  p_orig_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && nxt_fine && !nxt_drop |=> out_hdr[15:12] == {$past(in_pcp), $past(in_dei)});
  p_zero_on_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_drop |-> out_hdr == 64'h0);
  p_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && drop_miss |=> out_drop);
  p_xrange_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fine && !out_drop |-> !upper_reserved(out_hdr[43:32]));
  p_rsv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && drop_rsv |=> out_drop);
  p_vls_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && drop_vls |=> out_drop);
  p_plain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_fine |-> !out_drop && out_hdr[31:0] == 32'h0 && out_hdr[63:48] == ETYPE_CTAG);

endmodule

// File: tb/fgl_ingress_encap_test.sv
module fgl_ingress_encap_test;

  localparam int NP = 4;
  localparam int DP = 8;
  localparam int VC = 64;
  localparam int PW = 2;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_tbl_we = 0;
  logic [PW-1:0] cfg_tbl_port = '0;
  logic [IW-1:0] cfg_tbl_idx = '0;
  logic          cfg_tbl_valid = 0;
  logic [11:0]   cfg_tbl_vid = '0;
  logic [23:0]   cfg_tbl_label = '0;
  logic          cfg_port_we = 0;
  logic [PW-1:0] cfg_port_sel = '0;
  logic          cfg_port_fine = 0;
  logic          cfg_port_remap = 0;
  logic [2:0]    cfg_port_pcp = '0;
  logic          cfg_port_dei = 0;
  logic          cfg_vls_we = 0;
  logic [VC-1:0] cfg_vls_map = '0;
  logic          in_valid = 0;
  logic          in_ready;
  logic [PW-1:0] in_port = '0;
  logic          in_tagged = 0;
  logic [11:0]   in_vid = '0;
  logic [2:0]    in_pcp = '0;
  logic          in_dei = 0;
  logic          out_valid;
  logic          out_ready = 1;
  logic [63:0]   out_hdr;
  logic          out_fine;
  logic          out_drop;

  always #4 clk = ~clk;

  fgl_ingress_encap #(.NUM_PORTS(NP), .DEPTH(DP), .VLS_COUNT(VC)) uut (.*);

  int checks = 0;
  int failures = 0;

  // Shadow of what has been programmed.
  bit          sh_valid [NP][DP];
  logic [11:0] sh_vid   [NP][DP];
  logic [23:0] sh_label [NP][DP];
  bit          sh_fine  [NP];
  bit          sh_remap [NP];
  logic [2:0]  sh_pcp   [NP];
  bit          sh_dei   [NP];
  logic [VC-1:0] sh_vls;

  // Expected {fine, drop, hdr} from the requirements.
  function automatic logic [65:0] model(int p, bit tg, logic [11:0] vid,
                                        logic [2:0] pcp, bit dei);
    logic [11:0] v;
    bit          hit;
    logic [23:0] lab;
    logic [11:0] x;
    bit          dr;
    logic [3:0]  tnib;
    v   = tg ? vid : 12'd1;
    hit = 0;
    lab = '0;
    if (!sh_fine[p]) return {1'b0, 1'b0, 16'h8100, pcp, dei, v, 32'h0};
    for (int i = 0; i < DP; i++)
      if (!hit && sh_valid[p][i] && sh_vid[p][i] == v) begin
        hit = 1;
        lab = sh_label[p][i];
      end
    x  = lab[23:12];
    dr = !hit || x == 12'h000 || x == 12'hFFF || (x < 12'(VC) && sh_vls[x[5:0]]);
    if (dr) return {1'b1, 1'b1, 64'h0};
    tnib = sh_remap[p] ? {sh_pcp[p], sh_dei[p]} : {pcp, dei};
    return {1'b1, 1'b0, 16'h8100, tnib, x, 16'h893B, pcp, dei, lab[11:0]};
  endfunction

  task automatic chk(string req, logic [65:0] act, logic [65:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_ent(int p, int i, bit vld, logic [11:0] vid, logic [23:0] lab);
    @(negedge clk);
    cfg_tbl_we = 1; cfg_tbl_port = PW'(p); cfg_tbl_idx = IW'(i);
    cfg_tbl_valid = vld; cfg_tbl_vid = vid; cfg_tbl_label = lab;
    @(negedge clk);
    cfg_tbl_we = 0;
    sh_valid[p][i] = vld; sh_vid[p][i] = vid; sh_label[p][i] = lab;
  endtask

  task automatic wr_port(int p, bit fn, bit rm, logic [2:0] pcp, bit dei);
    @(negedge clk);
    cfg_port_we = 1; cfg_port_sel = PW'(p); cfg_port_fine = fn;
    cfg_port_remap = rm; cfg_port_pcp = pcp; cfg_port_dei = dei;
    @(negedge clk);
    cfg_port_we = 0;
    sh_fine[p] = fn; sh_remap[p] = rm; sh_pcp[p] = pcp; sh_dei[p] = dei;
  endtask

  task automatic wr_vls(logic [VC-1:0] m);
    @(negedge clk);
    cfg_vls_we = 1; cfg_vls_map = m;
    @(negedge clk);
    cfg_vls_we = 0;
    sh_vls = m;
  endtask

  task automatic drive(int p, bit tg, logic [11:0] vid, logic [2:0] pcp, bit dei);
    in_valid = 1; in_port = PW'(p); in_tagged = tg; in_vid = vid; in_pcp = pcp; in_dei = dei;
  endtask

  // Send one frame, sample the registered result one cycle later.
  task automatic send(string req, int p, bit tg, logic [11:0] vid, logic [2:0] pcp, bit dei,
                      output logic [65:0] got);
    @(negedge clk);
    drive(p, tg, vid, pcp, dei);
    out_ready = 1;
    @(posedge clk);
    #1 in_valid = 0;
    @(negedge clk);
    chk({req, " out_valid"}, {65'h0, out_valid}, 66'h1);
    got = {out_fine, out_drop, out_hdr};
    chk(req, got, model(p, tg, vid, pcp, dei));
  endtask

  logic [65:0] got;

  initial begin
    for (int p = 0; p < NP; p++) begin
      sh_fine[p] = 0; sh_remap[p] = 0; sh_pcp[p] = 0; sh_dei[p] = 0;
      for (int i = 0; i < DP; i++) begin
        sh_valid[p][i] = 0; sh_vid[p][i] = 0; sh_label[p][i] = 0;
      end
    end
    sh_vls = '0;
    void'($urandom(32'h5EED1));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R12: reset state.
    chk("R12 out_valid", {65'h0, out_valid}, 66'h0);
    chk("R12 in_ready", {65'h0, in_ready}, 66'h1);
    send("R12 fresh port plain", 2, 1, 12'h00A, 3'd0, 0, got);

    // R10: plain tag, literal value.
    send("R10 plain tag", 0, 1, 12'h005, 3'd3, 1, got);
    chk("R10 literal", got, {2'b00, 64'h8100_7005_0000_0000});

    // R1 R2 R3 R4: fine header with original priority copied.
    wr_port(1, 1, 0, 3'd0, 0);
    wr_ent(1, 0, 1, 12'd10, 24'h123456);
    send("R1 R2 R3 fine layout", 1, 1, 12'd10, 3'd5, 0, got);
    chk("R1 literal", got, {2'b10, 64'h8100_A123_893B_A456});
    wr_port(1, 1, 1, 3'd2, 1);
    send("R4 remapped transport priority", 1, 1, 12'd10, 3'd5, 0, got);
    chk("R4 literal", got, {2'b10, 64'h8100_5123_893B_A456});

    // R7: miss.
    send("R7 miss drops", 1, 1, 12'd11, 3'd1, 1, got);
    chk("R7 literal", got, {2'b11, 64'h0});

    // R6: untagged uses VLAN 1.
    wr_ent(1, 1, 1, 12'd1, 24'h200ABC);
    send("R6 untagged as vlan 1", 1, 0, 12'd77, 3'd4, 1, got);
    chk("R6 literal", got, {2'b10, 64'h8100_5200_893B_9ABC});

    // R8: reserved upper halves.
    wr_ent(1, 2, 1, 12'd20, 24'h000111);
    send("R8 X zero", 1, 1, 12'd20, 3'd0, 0, got);
    wr_ent(1, 2, 1, 12'd21, 24'hFFF222);
    send("R8 X all ones", 1, 1, 12'd21, 3'd0, 0, got);
    chk("R8 literal", got, {2'b11, 64'h0});

    // R9: reserved VLAN bitmap.
    wr_ent(1, 3, 1, 12'd22, 24'h030333);
    wr_vls(64'h0001_0000_0000_0000);
    send("R9 reserved X", 1, 1, 12'd22, 3'd0, 0, got);
    chk("R9 drop literal", got, {2'b11, 64'h0});
    wr_vls(64'h0);
    send("R9 X released", 1, 1, 12'd22, 3'd0, 0, got);
    wr_ent(1, 4, 1, 12'd23, 24'h040444);
    wr_vls({VC{1'b1}});
    send("R9 X past bitmap", 1, 1, 12'd23, 3'd0, 0, got);
    chk("R9 pass literal", got[65:64], 2'b10);
    wr_vls(64'h0);

    // R5: duplicate keys, lowest index wins.
    wr_ent(2, 3, 1, 12'd30, 24'h300001);
    wr_ent(2, 4, 1, 12'd30, 24'h400002);
    wr_port(2, 1, 0, 3'd0, 0);
    send("R5 lowest index wins", 2, 1, 12'd30, 3'd0, 0, got);
    chk("R5 literal", got[43:32], 66'h300);
    wr_ent(2, 3, 0, 12'd30, 24'h300001);
    send("R5 invalidated entry skipped", 2, 1, 12'd30, 3'd0, 0, got);

    // R11: backpressure.
    begin
      logic [65:0] ea;
      logic [65:0] eb;
      ea = model(1, 1, 12'd10, 3'd6, 1);
      eb = model(0, 1, 12'd9, 3'd1, 0);
      @(negedge clk);
      out_ready = 0;
      drive(1, 1, 12'd10, 3'd6, 1);
      @(posedge clk);
      #1 in_valid = 0;
      @(negedge clk);
      chk("R11 latency one", {65'h0, out_valid}, 66'h1);
      chk("R11 first result", {out_fine, out_drop, out_hdr}, ea);
      drive(0, 1, 12'd9, 3'd1, 0);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk("R11 ready low in stall", {65'h0, in_ready}, 66'h0);
        chk("R11 held result", {out_fine, out_drop, out_hdr}, ea);
      end
      out_ready = 1;
      @(posedge clk);
      #1 in_valid = 0;
      @(negedge clk);
      chk("R11 second after release", {out_fine, out_drop, out_hdr}, eb);
      @(negedge clk);
      chk("R11 drained", {65'h0, out_valid}, 66'h0);
    end

    // Random phase against the model.
    for (int round = 0; round < 6; round++) begin
      for (int p = 0; p < NP; p++)
        wr_port(p, ($urandom % 4) != 0, $urandom % 2, 3'($urandom), $urandom % 2);
      for (int p = 0; p < NP; p++)
        for (int i = 0; i < DP; i++) begin
          logic [11:0] rx;
          case ($urandom % 6)
            0: rx = 12'h000;
            1: rx = 12'hFFF;
            2: rx = 12'($urandom % VC);
            default: rx = 12'($urandom);
          endcase
          wr_ent(p, i, ($urandom % 4) != 0, 12'(1 + $urandom % 8), {rx, 12'($urandom)});
        end
      wr_vls({$urandom, $urandom});
      for (int n = 0; n < 50; n++)
        send("R2 R5 R9 random", $urandom % NP, $urandom % 3 != 0, 12'(1 + $urandom % 9),
             3'($urandom), $urandom % 2, got);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule